// File: doc/BRIEF.md
# Burst Host Bus Target Responder

This block is the memory-side target of a 64-bit processor host bus that can burst. It samples an active-low address strobe and, on that edge, latches the quadword address, the byte enables and the cycle attributes: memory or I/O, data or code, write or read, locked, cacheable. It then decides whether the cycle is one transfer or a four-beat line transfer and serves each beat through a synchronous request/acknowledge memory port. For each acknowledged beat it returns one active-low ready strobe to the processor.

During a line transfer the block can drive an early next-address strobe. The processor may then issue its next cycle before the current one ends. That cycle waits in a single holding slot and starts on the clock that follows the last beat of the current cycle, with no idle clock between them. A locked sequence keeps a lock output asserted toward memory from its first cycle until the bus goes idle with the lock input released.

Top module: `hbus_target`

## Requirements
- R1: While reset is asserted and right after it, `host_rdy_n` and `host_na_n` are high and `mem_req` and `mem_lock` are low.
- R2: A cycle starts only on a rising clock edge that samples `host_ads_n` low. Address, byte enables and cycle attributes are latched on that edge, so later changes on those inputs do not alter `mem_addr`, `mem_we`, `mem_io` or `mem_data_acc` for that cycle.
- R3: A memory cycle (`host_mio`=1) with `host_cache_n`=0 returns exactly four ready strobes. Any other cycle, including I/O with `host_cache_n`=0, returns exactly one. After the final strobe, no further strobe appears and `mem_req` falls.
- R4: Beat k (k=0..3) of a line transfer addresses quadword `{A[QW-1:2], A[1:0] XOR k}`, where A is the latched quadword address. The bits above the two low ones stay fixed for the whole line.
- R5: `host_wr`=1 marks a write. On a single write, `mem_be` is the inverse of the latched `host_be_n`, with bit 7 enabling data bits 63:56 and bit 0 enabling bits 7:0. On a line write, `mem_be` is all ones.
- R6: On every read, `mem_be` is all ones and `host_rdata` carries the full 64-bit `mem_rdata`, whatever `host_be_n` held.
- R7: `host_na_n` goes low for exactly one clock per line transfer. This happens on the first clock on which at least two beats have completed and no cycle is held. It never goes low during a single transfer.
- R8: A strobe accepted after next-address is held and begins on the clock after the current cycle's last beat. Only one cycle is held. Further strobes are ignored while the slot is full.
- R9: A strobe sampled while a cycle is in progress and next-address has not been given is ignored.
- R10: `host_rdy_n` is high on every clock on which `mem_ack` is low.
- R11: `mem_lock` is high during every cycle latched with `host_lock_n`=0. It stays high through idle clocks while `host_lock_n` remains low, and drops once the bus is idle and `host_lock_n` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ads_n | input | 1 | Address strobe, active low |
| host_addr | input | AW-3 | Quadword address (byte address bits AW-1:3) |
| host_be_n | input | DW/8 | Byte enables, active low, bit 7 = most significant byte |
| host_mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| host_dc | input | 1 | 1 = data access, 0 = code access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_lock_n | input | 1 | Locked cycle, active low |
| host_cache_n | input | 1 | Cacheable / line transfer request, active low |
| host_wdata | input | DW | Write data for the current beat |
| host_rdata | output | DW | Read data for the current beat |
| host_rdy_n | output | 1 | Beat ready, active low |
| host_na_n | output | 1 | Next address may be issued, active low |
| mem_req | output | 1 | Beat request toward memory |
| mem_we | output | 1 | Beat is a write |
| mem_io | output | 1 | Beat belongs to an I/O cycle |
| mem_data_acc | output | 1 | Beat belongs to a data (not code) cycle |
| mem_addr | output | AW-3 | Quadword address of the beat |
| mem_be | output | DW/8 | Active-high byte mask of the beat |
| mem_wdata | output | DW | Write data toward memory |
| mem_rdata | input | DW | Read data from memory |
| mem_ack | input | 1 | Memory completes the beat on this clock |
| mem_lock | output | 1 | Locked sequence in progress |

## Verification
The hardest case to reach from the ports is the pipelined hand-over. A second strobe must arrive in the single clock on which next-address is low, and a third strobe must land while the holding slot is full and the line transfer still has beats left. The stimulus watches `host_na_n` at each mid-cycle sample and drives the strobe for the very next edge. It then holds the strobe low for one more edge with a different address. This runs under a memory model that inserts a chosen number of wait clocks per beat. The bench checks the addresses of all five beats, checks that `mem_req` never drops between the two cycles, and checks that the third request never shows up.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  // Attributes of one latched host cycle.
  typedef struct packed {
    logic wr;        // 1 = write
    logic io;        // 1 = I/O space
    logic data_acc;  // 1 = data access
    logic lock;      // locked sequence member
    logic burst;     // four-beat line transfer
  } hbus_kind_t;

endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int BEW = 8
) (
  input  logic           mio,
  input  logic           dc,
  input  logic           wr,
  input  logic           lock_n,
  input  logic           cache_n,
  input  logic [BEW-1:0] be_n,
  output hbus_kind_t     kind,
  output logic [BEW-1:0] be_mask
);

  always_comb begin
    kind.wr       = wr;
    kind.io       = !mio;
    kind.data_acc = dc;
    kind.lock     = !lock_n;
    kind.burst    = mio && !cache_n;
    // reads and line writes always move the whole quadword
    if (!wr || kind.burst) be_mask = '1;
    else                   be_mask = ~be_n;
  end

endmodule

// File: rtl/hbus_slot.sv
module hbus_slot
  import hbus_pkg::*;
#(
  parameter int QW  = 29,
  parameter int BEW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  hbus_kind_t     d_kind,
  input  logic [QW-1:0]  d_addr,
  input  logic [BEW-1:0] d_be,
  output hbus_kind_t     q_kind,
  output logic [QW-1:0]  q_addr,
  output logic [BEW-1:0] q_be
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_kind <= '0;
      q_addr <= '0;
      q_be   <= '0;
    end else if (load) begin
      q_kind <= d_kind;
      q_addr <= d_addr;
      q_be   <= d_be;
    end
  end

endmodule

// File: rtl/hbus_beat.sv
module hbus_beat #(
  parameter int BEATS = 4,
  parameter int BW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          burst,
  input  logic [BW-1:0] start,
  output logic [BW-1:0] off,
  output logic          last,
  output logic          late
);

  logic [BW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign off  = start ^ idx_q;
  assign last = !burst || (idx_q == BW'(BEATS-1));
  assign late = burst && (idx_q >= BW'(BEATS-2));

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !last) |=> (off != $past(off))); // R4

endmodule

// File: rtl/hbus_target.sv
module hbus_target
  import hbus_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ads_n,
  input  logic [AW-4:0]     host_addr,
  input  logic [DW/8-1:0]   host_be_n,
  input  logic              host_mio,
  input  logic              host_dc,
  input  logic              host_wr,
  input  logic              host_lock_n,
  input  logic              host_cache_n,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rdy_n,
  output logic              host_na_n,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_io,
  output logic              mem_data_acc,
  output logic [AW-4:0]     mem_addr,
  output logic [DW/8-1:0]   mem_be,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic              mem_lock
);

  localparam int QW  = AW - 3;
  localparam int BEW = DW / 8;
  localparam int BW  = $clog2(BEATS);

  // decoded strobe-time attributes
  hbus_kind_t     dec_kind;
  logic [BEW-1:0] dec_be;

  hbus_decode #(.BEW(BEW)) i_decode (
    .mio     (host_mio),
    .dc      (host_dc),
    .wr      (host_wr),
    .lock_n  (host_lock_n),
    .cache_n (host_cache_n),
    .be_n    (host_be_n),
    .kind    (dec_kind),
    .be_mask (dec_be)
  );

  // control state
  logic busy_q, busy_d;
  logic pend_v_q, pend_v_d;
  logic na_done_q, na_done_d;
  logic lock_q, lock_d;

  // control strobes
  logic ads_hit, accept_ok, last_ack, take_new, from_pend, to_pend, load_cur;
  logic beat_last, beat_late, na_active;
  logic [BW-1:0] beat_off;

  // slots
  hbus_kind_t     cur_kind, pend_kind, cur_d_kind;
  logic [QW-1:0]  cur_addr, pend_addr, cur_d_addr;
  logic [BEW-1:0] cur_be, pend_be, cur_d_be;

  hbus_slot #(.QW(QW), .BEW(BEW)) i_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (to_pend),
    .d_kind (dec_kind),
    .d_addr (host_addr),
    .d_be   (dec_be),
    .q_kind (pend_kind),
    .q_addr (pend_addr),
    .q_be   (pend_be)
  );

  always_comb begin
    if (from_pend) begin
      cur_d_kind = pend_kind;
      cur_d_addr = pend_addr;
      cur_d_be   = pend_be;
    end else begin
      cur_d_kind = dec_kind;
      cur_d_addr = host_addr;
      cur_d_be   = dec_be;
    end
  end

  hbus_slot #(.QW(QW), .BEW(BEW)) i_cur (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_cur),
    .d_kind (cur_d_kind),
    .d_addr (cur_d_addr),
    .d_be   (cur_d_be),
    .q_kind (cur_kind),
    .q_addr (cur_addr),
    .q_be   (cur_be)
  );

  hbus_beat #(.BEATS(BEATS), .BW(BW)) i_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_cur),
    .adv   (busy_q && mem_ack),
    .burst (cur_kind.burst),
    .start (cur_addr[BW-1:0]),
    .off   (beat_off),
    .last  (beat_last),
    .late  (beat_late)
  );

  // next-state logic
  always_comb begin
    na_active = busy_q && beat_late && !na_done_q && !pend_v_q;
    accept_ok = !busy_q || ((na_done_q || na_active) && !pend_v_q);
    ads_hit   = !host_ads_n && accept_ok;
    last_ack  = busy_q && mem_ack && beat_last;
    from_pend = last_ack && pend_v_q;
    take_new  = ads_hit && (!busy_q || last_ack);
    to_pend   = ads_hit && busy_q && !last_ack;
    load_cur  = take_new || from_pend;

    busy_d = busy_q;
    if (load_cur)      busy_d = 1'b1;
    else if (last_ack) busy_d = 1'b0;

    pend_v_d = pend_v_q;
    if (to_pend)        pend_v_d = 1'b1;
    else if (from_pend) pend_v_d = 1'b0;

    na_done_d = na_done_q;
    if (load_cur)       na_done_d = 1'b0;
    else if (na_active) na_done_d = 1'b1;

    lock_d = lock_q;
    if (load_cur)                    lock_d = cur_d_kind.lock;
    else if (!busy_q && host_lock_n) lock_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pend_v_q  <= 1'b0;
      na_done_q <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      pend_v_q  <= pend_v_d;
      na_done_q <= na_done_d;
      lock_q    <= lock_d;
    end
  end

  // outputs
  assign host_rdy_n   = !(busy_q && mem_ack);
  assign host_na_n    = !na_active;
  assign host_rdata   = mem_rdata;
  assign mem_req      = busy_q;
  assign mem_we       = cur_kind.wr;
  assign mem_io       = cur_kind.io;
  assign mem_data_acc = cur_kind.data_acc;
  assign mem_addr     = {cur_addr[QW-1:BW], beat_off};
  assign mem_be       = cur_be;
  assign mem_wdata    = host_wdata;
  assign mem_lock     = lock_q;

  AST_NA_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !host_na_n |=> host_na_n); // R7

  AST_READ_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (&mem_be)); // R6

  AST_LINE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req) && !$past(last_ack))
      |-> (mem_addr[QW-1:BW] == $past(mem_addr[QW-1:BW]))); // R4

  AST_PEND_AFTER_NA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_v_q) |-> $past(na_done_q || !host_na_n)); // R8

  AST_LOCK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cur_kind.lock) |-> mem_lock); // R11

endmodule

// File: tb/test_hbus_target.sv
module test_hbus_target;

  localparam int QW = 29;

  logic          clk;
  logic          rst_n;
  logic          host_ads_n;
  logic [QW-1:0] host_addr;
  logic [7:0]    host_be_n;
  logic          host_mio, host_dc, host_wr, host_lock_n, host_cache_n;
  logic [63:0]   host_wdata, host_rdata;
  logic          host_rdy_n, host_na_n;
  logic          mem_req, mem_we, mem_io, mem_data_acc, mem_lock;
  logic [QW-1:0] mem_addr;
  logic [7:0]    mem_be;
  logic [63:0]   mem_wdata, mem_rdata;
  logic          mem_ack;

  hbus_target i_hbus_target (
    .clk(clk), .rst_n(rst_n),
    .host_ads_n(host_ads_n), .host_addr(host_addr), .host_be_n(host_be_n),
    .host_mio(host_mio), .host_dc(host_dc), .host_wr(host_wr),
    .host_lock_n(host_lock_n), .host_cache_n(host_cache_n),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rdy_n(host_rdy_n), .host_na_n(host_na_n),
    .mem_req(mem_req), .mem_we(mem_we), .mem_io(mem_io),
    .mem_data_acc(mem_data_acc), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_lock(mem_lock)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ws = 0;
  int ack_cnt = 0;
  int seq = 0;
  bit done = 0;

  logic [63:0] mdl  [16];
  logic [63:0] expm [16];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model: acknowledge after ws wait clocks
  always @(negedge clk) begin
    if (mem_req && ack_cnt >= ws) begin
      mem_ack <= 1'b1;
      ack_cnt <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req) ack_cnt <= ack_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we)
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mdl[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  assign mem_rdata = mdl[mem_addr[3:0]];

  task automatic chk(input string r, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] wpat(input int k);
    return {32'(seq) * 32'h9E37_79B9 + 32'(k), ~(32'(seq) + 32'(k) * 32'h0100_0193)};
  endfunction

  task automatic run_cycle(input logic [QW-1:0] a, input logic [7:0] ben, input logic w,
                           input logic cn, input logic m, input logic ln, input bit intr);
    int nb, got, nna, guard;
    logic [QW-1:0] qa;
    logic [7:0] ebe;
    logic dcv;
    nb = (m && !cn) ? 4 : 1;
    got = 0; nna = 0; guard = 0;
    seq++;
    dcv = seq[0];
    @(negedge clk);
    host_ads_n = 1'b0; host_addr = a; host_be_n = ben; host_wr = w;
    host_cache_n = cn; host_mio = m; host_dc = dcv; host_lock_n = ln;
    host_wdata = wpat(0);
    @(negedge clk);
    // R2: scramble everything after the strobe edge
    host_ads_n = 1'b1; host_addr = ~a; host_be_n = ~ben; host_wr = ~w;
    host_cache_n = ~cn; host_mio = ~m; host_dc = ~dcv;
    #1;
    while (got < nb && guard < 400) begin
      host_wdata = wpat(got);
      if (!host_na_n) begin
        nna++;
        chk("R7 na timing", (nb == 4) && (got >= 2), 64'(got), 64'd2);
      end
      if (!mem_ack) chk("R10 ready without ack", host_rdy_n == 1'b1, 64'(host_rdy_n), 64'd1);
      if (!host_rdy_n) begin
        qa = {a[QW-1:2], a[1:0] ^ 2'(got)};
        chk("R4 beat address", mem_addr == qa, 64'(mem_addr), 64'(qa));
        chk("R2 latched attrs", {mem_we, mem_io, mem_data_acc} == {w, !m, dcv},
            64'({mem_we, mem_io, mem_data_acc}), 64'({w, !m, dcv}));
        chk("R11 lock during cycle", mem_lock == !ln, 64'(mem_lock), 64'(!ln));
        if (w) begin
          ebe = (nb == 4) ? 8'hFF : ~ben;
          chk("R5 write mask", mem_be == ebe, 64'(mem_be), 64'(ebe));
          for (int b = 0; b < 8; b++)
            if (ebe[b]) expm[qa[3:0]][8*b +: 8] = host_wdata[8*b +: 8];
        end else begin
          chk("R6 read mask", mem_be == 8'hFF, 64'(mem_be), 64'hFF);
          chk("R6 read data", host_rdata == expm[qa[3:0]], host_rdata, expm[qa[3:0]]);
        end
        got++;
      end
      if (intr && guard == 1) begin
        host_ads_n = 1'b0; host_addr = a + 29'd3; host_wr = 1'b1; host_mio = 1'b1; host_cache_n = 1'b0;
      end else if (intr && guard == 2) begin
        host_ads_n = 1'b1;
      end
      @(negedge clk); #1;
      guard++;
    end
    chk("R3 beat count", got == nb, 64'(got), 64'(nb));
    chk("R7 na count", nna == ((nb == 4) ? 1 : 0), 64'(nna), 64'((nb == 4) ? 1 : 0));
    for (int i = 0; i < 3; i++) begin
      chk(intr ? "R9 strobe ignored" : "R3 no extra ready",
          host_rdy_n && !mem_req, 64'({host_rdy_n, mem_req}), 64'b10);
      @(negedge clk); #1;
    end
  endtask

  task automatic run_pipe(input int wsv);
    int got, nna, issued, guard;
    bit gap_pending;
    logic [QW-1:0] a1, a2, qa;
    a1 = 29'h0000_0005;
    a2 = 29'h0000_000A;
    ws = wsv;
    got = 0; nna = 0; issued = 0; guard = 0; gap_pending = 0;
    seq++;
    @(negedge clk);
    host_ads_n = 1'b0; host_addr = a1; host_wr = 1'b0; host_mio = 1'b1;
    host_cache_n = 1'b0; host_lock_n = 1'b1; host_be_n = 8'h00;
    @(negedge clk);
    host_ads_n = 1'b1;
    #1;
    while (got < 5 && guard < 400) begin
      if (gap_pending) begin
        chk("R8 no idle between cycles", mem_req == 1'b1, 64'(mem_req), 64'd1);
        gap_pending = 0;
      end
      if (!host_rdy_n) begin
        qa = (got < 4) ? {a1[QW-1:2], a1[1:0] ^ 2'(got)} : a2;
        chk("R8 pipelined beat address", mem_addr == qa, 64'(mem_addr), 64'(qa));
        chk("R8 pipelined data", host_rdata == expm[qa[3:0]], host_rdata, expm[qa[3:0]]);
        got++;
        if (got == 4) gap_pending = 1;
      end
      if (!host_na_n) nna++;
      if (!host_na_n && issued == 0) begin
        host_ads_n = 1'b0; host_addr = a2; host_wr = 1'b0; host_mio = 1'b1; host_cache_n = 1'b1;
        issued = 1;
      end else if (issued == 1) begin
        host_ads_n = 1'b0; host_addr = 29'h0000_000F; host_wr = 1'b1; host_cache_n = 1'b0;
        issued = 2;
      end else if (issued == 2) begin
        host_ads_n = 1'b1;
        issued = 3;
      end
      @(negedge clk); #1;
      guard++;
    end
    chk("R8 total beats", got == 5, 64'(got), 64'd5);
    chk("R7 na once in pipeline", nna == 1, 64'(nna), 64'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R8 single slot, extra strobe dropped", host_rdy_n && !mem_req,
          64'({host_rdy_n, mem_req}), 64'b10);
      @(negedge clk); #1;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mdl[i]  = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h0101_0101_0101_0101);
      expm[i] = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h0101_0101_0101_0101);
    end
    mem_ack = 1'b0;
    rst_n = 1'b0;
    host_ads_n = 1'b1; host_addr = '0; host_be_n = '1; host_mio = 1'b1; host_dc = 1'b1;
    host_wr = 1'b0; host_lock_n = 1'b1; host_cache_n = 1'b1; host_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", host_rdy_n && host_na_n && !mem_req && !mem_lock,
        64'({host_rdy_n, host_na_n, mem_req, mem_lock}), 64'b1100);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 after reset", host_rdy_n && host_na_n && !mem_req && !mem_lock,
        64'({host_rdy_n, host_na_n, mem_req, mem_lock}), 64'b1100);

    // R2: no strobe, toggling attributes, nothing starts
    for (int i = 0; i < 5; i++) begin
      host_addr = 29'(i * 7); host_wr = i[0]; host_cache_n = i[1]; host_be_n = 8'(i);
      @(negedge clk); #1;
      chk("R2 no start without strobe", !mem_req && host_rdy_n, 64'(mem_req), 64'd0);
    end

    // sweep: wait states x start offset x cacheable, write then read back
    for (int s = 0; s < 3; s++) begin
      ws = s;
      for (int o = 0; o < 4; o++) begin
        for (int c = 0; c < 2; c++) begin
          logic [QW-1:0] a;
          logic [7:0] ben;
          a   = QW'(s * 4 + o);
          ben = ~(8'h81 << o) ^ (c[0] ? 8'h30 : 8'h00);
          run_cycle(a, ben, 1'b1, c[0], 1'b1, 1'b1, 1'b0);
          run_cycle(a, ~ben, 1'b0, c[0], 1'b1, 1'b1, 1'b0);
        end
      end
    end

    // I/O cycles with cacheable low stay single (R3)
    ws = 1;
    run_cycle(29'h0000_000D, 8'hF0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(29'h0000_000D, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R9: strobe during a single cycle without next-address
    ws = 4;
    run_cycle(29'h0000_0003, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);

    // R8: pipelined cycles at two wait settings
    run_pipe(0);
    run_pipe(2);

    // R11: locked sequence
    ws = 1;
    run_cycle(29'h0000_0006, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      chk("R11 lock held while idle", mem_lock == 1'b1, 64'(mem_lock), 64'd1);
      @(negedge clk); #1;
    end
    run_cycle(29'h0000_0004, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    host_lock_n = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    chk("R11 lock released", mem_lock == 1'b0, 64'(mem_lock), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule